// File: doc/BRIEF.md
# ATM Cell Ingress with Parity Discard

This block sits at the transmit side of a cell interface and receives ATM cells from an ATM-layer device, one byte or one 16-bit word per transfer. It finds cell boundaries from a start-of-cell marker and an octet count. It checks odd parity on every transfer against the parity bit the sender drives. Each complete cell is handed to a downstream cell FIFO as one wide write. A cell that saw a parity error is either dropped whole or passed on with an error flag, depending on a control bit.

The cell length follows two configuration bits. Without the 52-octet mode a cell is 53 octets on an 8-bit bus and 54 octets on a 16-bit bus. With the 52-octet mode set it is 52 octets on either width. Octets of a cell are collected in a staging buffer, so a cell that is dropped, aborted or flushed never reaches the FIFO in part. A sticky parity-error status bit is cleared by a read strobe and drives an interrupt line through an enable bit.

Top module: `atm_cell_ingress`

## Requirements
- R1: With `cfg_cell52`=0 and `cfg_wide`=0, a cell is 53 transfers of one octet (data bits 7:0). The cell is written after its 53rd transfer and not before.
- R2: With `cfg_cell52`=0 and `cfg_wide`=1, a cell is 27 transfers of two octets (54 octets). Bits 15:8 of each word are the earlier octet and bits 7:0 the later one.
- R3: With `cfg_cell52`=1, a cell is 52 octets on either width: 52 transfers on the 8-bit bus or 26 on the 16-bit bus.
- R4: A transfer is parity-good when the data bits in use plus `tx_parity` hold an odd number of ones. The bits in use are 7:0 on the 8-bit bus and 15:0 on the 16-bit bus. Bits 15:8 take no part in parity or data on the 8-bit bus.
- R5: A parity mismatch on any transfer with `tx_valid`=1 sets `perr_status` from the next cycle on. It stays set until it is read.
- R6: `stat_rd`=1 clears `perr_status` for the next cycle. If a mismatch arrives in the same cycle as the read, the status stays set.
- R7: `perr_irq` is high exactly when `perr_status` and `cfg_int_en` are both 1.
- R8: A cell with at least one mismatched transfer produces no write when `cfg_discard`=1. When `cfg_discard`=0 it is written with `cell_err`=1. Error-free cells are written with `cell_err`=0.
- R9: A transfer with `tx_soc`=1 always starts a new cell at octet 0. A partial cell it interrupts is never written.
- R10: Transfers with `tx_soc`=0 while no cell is open are ignored. They write no cell and do not count toward a later cell.
- R11: `fifo_flush`=1 closes any open cell without writing it, and the transfer in that cycle is ignored.
- R12: `cell_wr` is a one-cycle pulse in the cycle after the clock edge that takes a cell's last transfer. During that pulse, octet k of the cell is on `cell_data` bits 8k+7:8k, and octets at and beyond the cell length read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus |
| cfg_cell52 | input | 1 | 1 selects 52-octet cells |
| cfg_discard | input | 1 | 1 drops cells that contain a parity error |
| cfg_int_en | input | 1 | Enables the parity-error interrupt |
| fifo_flush | input | 1 | Abandons the open cell |
| tx_valid | input | 1 | A transfer is on the bus this cycle |
| tx_soc | input | 1 | This transfer is the first of a cell |
| tx_data | input | 16 | Transfer data |
| tx_parity | input | 1 | Odd parity bit from the sender |
| stat_rd | input | 1 | Read strobe that clears the status bit |
| cell_wr | output | 1 | Write pulse toward the cell FIFO |
| cell_data | output | 432 | Whole cell, octet k at bits 8k+7:8k |
| cell_err | output | 1 | Written cell contained a parity error |
| perr_status | output | 1 | Sticky parity-error status |
| perr_irq | output | 1 | Parity-error interrupt |

## Verification
The bench targets the length boundaries in all four width and mode combinations. A design with the wrong count would write one transfer early or late, or merge two cells. It also drives a parity error on the first and on the last transfer of a cell with discard on and off. A design that judged only the current transfer would leak a bad cell or drop a good one. Other cases are a start-of-cell in mid-cell, idle transfers without start-of-cell, and a flush with a live transfer. Here a faulty design would emit a partial cell or shift octets. Finally it covers a read landing in the same cycle as a new error, which a design that let the clear win would lose.

// File: rtl/atm_ingress_pkg.sv
// Shared sizes for the cell ingress block.
// Assumes octets of 8 bits and a bus of at most two octet lanes.
package atm_ingress_pkg;
    localparam int OCT_W    = 8;
    localparam int DATA_W   = 16;
    localparam int LANES    = DATA_W / OCT_W;
    localparam int LEN_NARROW = 53;
    localparam int LEN_WIDE   = 54;
    localparam int LEN_SHORT  = 52;
    localparam int MAX_OCT  = (LEN_NARROW > LEN_WIDE) ? LEN_NARROW : LEN_WIDE;
    localparam int CNT_W    = $clog2(MAX_OCT + 1);
    localparam int CELL_W   = MAX_OCT * OCT_W;
endpackage

// File: rtl/tx_parity_check.sv
// Odd-parity checker for one bus transfer.
// Computes parity per octet lane; in narrow mode only lane 0 counts.
// Assumes DATA_W is a multiple of 8 with at least two lanes.
module tx_parity_check #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] data,
    input  logic              wide,
    input  logic              par,
    output logic              mismatch
);
    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] lane_par;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_par[g] = ^data[g*8 +: 8];
        end
    endgenerate

    logic upper_par;
    logic total;

    // Parity of the upper lanes, used only on the wide bus.
    always_comb begin
        upper_par = 1'b0;
        for (int i = 1; i < LANES; i++) upper_par = upper_par ^ lane_par[i];
    end

    // Odd parity: bits in use plus parity bit must have an odd count of ones.
    always_comb begin
        total    = lane_par[0] ^ (wide ? upper_par : 1'b0) ^ par;
        mismatch = ~total;
    end
endmodule

// File: rtl/cell_delineator.sv
// Tracks cell boundaries by start-of-cell marker and octet count.
// Decides per transfer whether it belongs to a cell, where it lands and
// whether it closes the cell. Assumes configuration is stable within a cell.
module cell_delineator
    import atm_ingress_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wide,
    input  logic             cfg_cell52,
    input  logic             flush,
    input  logic             valid,
    input  logic             soc,
    output logic             take,
    output logic             start,
    output logic             last,
    output logic [CNT_W-1:0] offset
);
    logic             in_cell;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cell_len;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] next_cnt;

    // Cell length and per-transfer octet step from configuration.
    always_comb begin
        if (cfg_cell52)    cell_len = CNT_W'(LEN_SHORT);
        else if (cfg_wide) cell_len = CNT_W'(LEN_WIDE);
        else               cell_len = CNT_W'(LEN_NARROW);
        step = cfg_wide ? CNT_W'(2) : CNT_W'(1);
    end

    // Classify the current transfer.
    always_comb begin
        take     = valid && !flush && (soc || in_cell);
        start    = take && soc;
        offset   = start ? '0 : cnt;
        next_cnt = offset + step;
        last     = take && (next_cnt == cell_len);
    end

    // Octet counter and open-cell flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cell <= 1'b0;
            cnt     <= '0;
        end else if (flush) begin
            in_cell <= 1'b0;
            cnt     <= '0;
        end else if (take) begin
            if (last) begin
                in_cell <= 1'b0;
                cnt     <= '0;
            end else begin
                in_cell <= 1'b1;
                cnt     <= next_cnt;
            end
        end
    end

    // R1 R2 R3: an open cell never holds a full cell's worth of octets.
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_cell |-> (cnt < cell_len));

    // R9: a start-of-cell transfer restarts counting from its own octets.
    a_r9_soc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !last) |=> (in_cell && cnt == $past(step)));

    // R11: a flush leaves no open cell.
    a_r11_flush_closes: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !in_cell);
endmodule

// File: rtl/cell_assembler.sv
// Stages the octets of one cell and issues a single write when it completes.
// Tracks whether any transfer of the cell failed parity and drops the cell
// when discard is enabled. Assumes offset and last come from the delineator.
module cell_assembler
    import atm_ingress_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              start,
    input  logic              last,
    input  logic [CNT_W-1:0]  offset,
    input  logic              wide,
    input  logic [DATA_W-1:0] data,
    input  logic              perr,
    input  logic              discard,
    output logic              cell_wr,
    output logic [CELL_W-1:0] cell_data,
    output logic              cell_err
);
    logic [OCT_W-1:0]  buf_q [MAX_OCT];
    logic [OCT_W-1:0]  buf_d [MAX_OCT];
    logic [CELL_W-1:0] flat_d;
    logic              err_q;
    logic              err_d;

    // Next buffer contents: cleared on a new cell, then this transfer's octets.
    always_comb begin
        buf_d = buf_q;
        if (start) begin
            for (int k = 0; k < MAX_OCT; k++) buf_d[k] = '0;
        end
        if (wide) begin
            for (int j = 0; j < LANES; j++) begin
                if (int'(offset) + j < MAX_OCT)
                    buf_d[int'(offset) + j] = data[(LANES-1-j)*OCT_W +: OCT_W];
            end
        end else if (int'(offset) < MAX_OCT) begin
            buf_d[int'(offset)] = data[OCT_W-1:0];
        end
    end

    // Flatten the staged cell, octet k at bits 8k+7:8k.
    always_comb begin
        for (int k = 0; k < MAX_OCT; k++) flat_d[k*OCT_W +: OCT_W] = buf_d[k];
    end

    // Accumulated parity-error flag for the cell in progress.
    always_comb err_d = (start ? 1'b0 : err_q) | perr;

    // Staging registers and the FIFO write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MAX_OCT; k++) buf_q[k] <= '0;
            err_q     <= 1'b0;
            cell_wr   <= 1'b0;
            cell_err  <= 1'b0;
            cell_data <= '0;
        end else begin
            cell_wr <= 1'b0;
            if (take) begin
                buf_q <= buf_d;
                err_q <= err_d;
                if (last) begin
                    cell_wr   <= !(err_d && discard);
                    cell_err  <= err_d;
                    cell_data <= flat_d;
                end
            end
        end
    end

    // R8: a written cell carries an error only when discard was off.
    a_r8_no_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
        cell_wr |-> !(cell_err && $past(discard)));

    // R12: the write is a single-cycle pulse.
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cell_wr |=> !cell_wr);

    // R12: a write follows only the edge that took a cell's last transfer.
    a_r12_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last && !(err_d && discard)) |=> cell_wr);
endmodule

// File: rtl/perr_status_reg.sv
// Sticky parity-error status with clear-on-read and interrupt gating.
// A new error in the cycle of a read wins over the clear.
module perr_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd,
    input  logic int_en,
    output logic status,
    output logic irq
);
    // Set on error, clear on read, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= 1'b0;
        else        status <= hit | (status & ~rd);
    end

    // Interrupt line gated by its enable.
    always_comb irq = status & int_en;

    // R5: an error shows in the status on the next cycle.
    a_r5_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> status);

    // R5: the status holds until read.
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !rd) |=> status);

    // R6: a read without a new error clears the status.
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !hit) |=> !status);

    // R7: no interrupt while disabled.
    a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);
endmodule

// File: rtl/atm_cell_ingress.sv
// Cell ingress from an ATM-layer device: delineates cells by start marker
// and configured length, checks odd parity per transfer, stages each cell
// and writes it whole to the downstream cell FIFO or drops it on error.
// Assumes configuration inputs change only between cells or with a flush.
module atm_cell_ingress
    import atm_ingress_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_cell52,
    input  logic              cfg_discard,
    input  logic              cfg_int_en,
    input  logic              fifo_flush,
    input  logic              tx_valid,
    input  logic              tx_soc,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_parity,
    input  logic              stat_rd,
    output logic              cell_wr,
    output logic [CELL_W-1:0] cell_data,
    output logic              cell_err,
    output logic              perr_status,
    output logic              perr_irq
);
    logic             par_mismatch;
    logic             perr_hit;
    logic             take;
    logic             start;
    logic             last;
    logic [CNT_W-1:0] offset;

    tx_parity_check #(.DATA_W(DATA_W)) u_par (
        .data     (tx_data),
        .wide     (cfg_wide),
        .par      (tx_parity),
        .mismatch (par_mismatch)
    );

    // Parity is judged on every presented transfer.
    always_comb perr_hit = tx_valid & par_mismatch;

    cell_delineator u_delin (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wide   (cfg_wide),
        .cfg_cell52 (cfg_cell52),
        .flush      (fifo_flush),
        .valid      (tx_valid),
        .soc        (tx_soc),
        .take       (take),
        .start      (start),
        .last       (last),
        .offset     (offset)
    );

    cell_assembler u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .start     (start),
        .last      (last),
        .offset    (offset),
        .wide      (cfg_wide),
        .data      (tx_data),
        .perr      (perr_hit),
        .discard   (cfg_discard),
        .cell_wr   (cell_wr),
        .cell_data (cell_data),
        .cell_err  (cell_err)
    );

    perr_status_reg u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (perr_hit),
        .rd     (stat_rd),
        .int_en (cfg_int_en),
        .status (perr_status),
        .irq    (perr_irq)
    );

    // R10 R11: an ignored transfer never produces a write on the next cycle.
    a_r10_ignored_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !last) |=> !cell_wr);
endmodule

// File: tb/atm_cell_ingress_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a bench-side model built from the requirements.
module atm_cell_ingress_tb;
    import atm_ingress_pkg::*;

    localparam int CLK_NS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wide = 1'b0, cfg_cell52 = 1'b0, cfg_discard = 1'b0, cfg_int_en = 1'b0;
    logic              fifo_flush = 1'b0, tx_valid = 1'b0, tx_soc = 1'b0, tx_parity = 1'b0, stat_rd = 1'b0;
    logic [DATA_W-1:0] tx_data = '0;
    logic              cell_wr, cell_err, perr_status, perr_irq;
    logic [CELL_W-1:0] cell_data;

    atm_cell_ingress u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_cell52(cfg_cell52),
        .cfg_discard(cfg_discard), .cfg_int_en(cfg_int_en), .fifo_flush(fifo_flush),
        .tx_valid(tx_valid), .tx_soc(tx_soc), .tx_data(tx_data), .tx_parity(tx_parity),
        .stat_rd(stat_rd), .cell_wr(cell_wr), .cell_data(cell_data), .cell_err(cell_err),
        .perr_status(perr_status), .perr_irq(perr_irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    n_cells  = 0;
    string cur_req  = "R1";

    // Bench model state.
    bit         m_in_cell = 0;
    int         m_cnt = 0;
    bit         m_err = 0;
    bit         m_stat = 0;
    logic [7:0] m_buf [MAX_OCT];

    function automatic logic good_par(input logic [15:0] d, input logic w);
        return w ? ~(^d) : ~(^d[7:0]);
    endfunction

    function automatic int len_of(input logic w, input logic c52);
        if (c52) return 52;
        return w ? 54 : 53;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [CELL_W-1:0] act, input logic [CELL_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle of stimulus, then model update and output comparison.
    task automatic step(input logic v, input logic s, input logic [15:0] d,
                        input logic p, input logic fl, input logic rd);
        logic              hit, take, e_wr, e_err;
        int                st, off, len;
        logic [CELL_W-1:0] e_data;
        tx_valid = v; tx_soc = s; tx_data = d; tx_parity = p;
        fifo_flush = fl; stat_rd = rd;
        @(posedge clk);
        #1;
        st   = cfg_wide ? 2 : 1;
        len  = len_of(cfg_wide, cfg_cell52);
        hit  = v && (p != good_par(d, cfg_wide));
        take = v && !fl && (s || m_in_cell);
        e_wr = 0; e_err = 0; e_data = '0;
        if (take) begin
            if (s) begin
                for (int k = 0; k < MAX_OCT; k++) m_buf[k] = 8'h00;
                m_cnt = 0; m_err = 0;
            end
            off = m_cnt;
            if (cfg_wide) begin
                m_buf[off] = d[15:8]; m_buf[off+1] = d[7:0];
            end else begin
                m_buf[off] = d[7:0];
            end
            m_err = m_err | hit;
            m_cnt = off + st;
            if (m_cnt == len) begin
                e_wr  = !(m_err && cfg_discard);
                e_err = m_err;
                for (int k = 0; k < MAX_OCT; k++) e_data[k*8 +: 8] = m_buf[k];
                m_in_cell = 0; m_cnt = 0;
            end else begin
                m_in_cell = 1;
            end
        end else if (fl) begin
            m_in_cell = 0; m_cnt = 0;
        end
        m_stat = hit | (m_stat & !rd);
        chk(cur_req, "cell_wr", CELL_W'(cell_wr), CELL_W'(e_wr));
        if (e_wr && cell_wr) begin
            n_cells++;
            chk(cur_req, "cell_data", cell_data, e_data);
            chk(cur_req, "cell_err", CELL_W'(cell_err), CELL_W'(e_err));
        end
        chk(cur_req, "perr_status", CELL_W'(perr_status), CELL_W'(m_stat));
        chk(cur_req, "perr_irq", CELL_W'(perr_irq), CELL_W'(m_stat & cfg_int_en));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 16'h0, 0, 0, 0);
    endtask

    // One full cell at the current configuration, error on transfer err_at.
    task automatic send_cell(input int err_at);
        int n;
        logic [15:0] d;
        n = len_of(cfg_wide, cfg_cell52) / (cfg_wide ? 2 : 1);
        for (int i = 0; i < n; i++) begin
            d = 16'($urandom);
            step(1, i == 0, d, good_par(d, cfg_wide) ^ (i == err_at), 0, 0);
        end
    endtask

    task automatic partial(input int n);
        logic [15:0] d;
        for (int i = 0; i < n; i++) begin
            d = 16'($urandom);
            step(1, i == 0, d, good_par(d, cfg_wide), 0, 0);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cells_before;
        void'($urandom(32'd20240611));
        for (int k = 0; k < MAX_OCT; k++) m_buf[k] = 8'h00;
        repeat (4) @(posedge clk);
        #1;
        chk("R12", "reset cell_wr", CELL_W'(cell_wr), '0);
        chk("R5", "reset perr_status", CELL_W'(perr_status), '0);
        chk("R7", "reset perr_irq", CELL_W'(perr_irq), '0);
        rst_n = 1'b1;
        idle(2);

        // R1 narrow 53-octet cells.
        cur_req = "R1"; cfg_wide = 0; cfg_cell52 = 0;
        cells_before = n_cells;
        send_cell(-1); send_cell(-1); idle(2);
        chk("R1", "cells written", CELL_W'(n_cells - cells_before), CELL_W'(2));

        // R2 wide 54-octet cells, high byte first.
        cur_req = "R2"; cfg_wide = 1;
        cells_before = n_cells;
        send_cell(-1); send_cell(-1); idle(2);
        chk("R2", "cells written", CELL_W'(n_cells - cells_before), CELL_W'(2));

        // R3 52-octet mode on both widths.
        cur_req = "R3"; cfg_cell52 = 1;
        send_cell(-1); cfg_wide = 0; send_cell(-1); idle(2);
        cfg_cell52 = 0;

        // R4 narrow bus: upper byte is noise, parity on low byte only.
        cur_req = "R4";
        for (int i = 0; i < 20; i++) begin
            logic [15:0] d;
            d = 16'($urandom);
            step(1, i == 0, d, good_par(d, 0), 0, 0);
        end
        step(0, 0, 0, 0, 0, 1);
        idle(2);

        // R8 discard on: errors at first and last transfer.
        cur_req = "R8"; cfg_discard = 1; cfg_int_en = 1;
        cells_before = n_cells;
        send_cell(0); send_cell(52); idle(1);
        chk("R8", "discarded cells", CELL_W'(n_cells - cells_before), '0);
        step(0, 0, 0, 0, 0, 1);
        cfg_discard = 0; cfg_wide = 1;
        send_cell(26); send_cell(5); idle(1);
        chk("R8", "kept cells", CELL_W'(n_cells - cells_before), CELL_W'(2));

        // R5 R6 R7 status read, read colliding with a new error, enable.
        cur_req = "R6";
        step(0, 0, 0, 0, 0, 1);
        step(1, 1, 16'h0001, 1'b1, 1, 0);
        step(1, 1, 16'h0003, 1'b0, 1, 1);
        chk("R6", "set wins over read", CELL_W'(perr_status), CELL_W'(1));
        cur_req = "R7"; cfg_int_en = 0; idle(1);
        chk("R7", "irq masked", CELL_W'(perr_irq), '0);
        cfg_int_en = 1; idle(1);
        chk("R7", "irq enabled", CELL_W'(perr_irq), CELL_W'(1));
        cur_req = "R5"; step(0, 0, 0, 0, 0, 1); idle(1);

        // R9 start-of-cell in mid-cell.
        cur_req = "R9"; cfg_wide = 0;
        partial(30); send_cell(-1);
        cfg_wide = 1; partial(26); send_cell(-1); idle(1);

        // R10 stray transfers without start-of-cell.
        cur_req = "R10";
        cells_before = n_cells;
        for (int i = 0; i < 60; i++) step(1, 0, 16'($urandom), 0, 0, 0);
        chk("R10", "stray transfers wrote nothing", CELL_W'(n_cells - cells_before), '0);
        step(0, 0, 0, 0, 0, 1);
        send_cell(-1);

        // R11 flush with a live transfer, then continuation ignored.
        cur_req = "R11"; cfg_wide = 0;
        partial(52);
        step(1, 0, 16'h00a5, good_par(16'h00a5, 0), 1, 0);
        for (int i = 0; i < 5; i++) step(1, 0, 16'h0011, good_par(16'h0011, 0), 0, 0);
        send_cell(-1); idle(1);

        // R12 random traffic across configurations.
        cur_req = "R12";
        for (int blk = 0; blk < 8; blk++) begin
            step(0, 0, 0, 0, 1, 0);
            cfg_wide    = 1'($urandom);
            cfg_cell52  = 1'($urandom);
            cfg_discard = 1'($urandom);
            cfg_int_en  = 1'($urandom);
            for (int i = 0; i < 450; i++) begin
                logic v, s, p, fl, rd;
                logic [15:0] d;
                d  = 16'($urandom);
                v  = ($urandom % 8) != 0;
                s  = m_in_cell ? (($urandom % 70) == 0) : (($urandom % 3) == 0);
                p  = good_par(d, cfg_wide) ^ (($urandom % 60) == 0);
                fl = ($urandom % 300) == 0;
                rd = ($urandom % 10) == 0;
                step(v, s, d, p, fl, rd);
            end
        end
        idle(2);
        finish_run();
    end
endmodule